// File: doc/BRIEF.md
# I2C High-Speed Mode Tracker

This block listens to an I2C bus without driving it. It samples SCL and SDA on a fast system clock through a synchroniser. From those samples it finds START, repeated START and STOP conditions and works out whether the bus is in Fast/Standard (F/S) signalling or in High-speed (HS) signalling. Other logic can use the `hs_mode` level to switch to HS timing or filtering, and use the single-cycle event pulses to log or sequence mode changes.

HS entry begins in F/S mode. The first byte after a START must carry the preamble pattern `00001XXX`, and the ninth bit slot after it must be a not-acknowledge. The next repeated START moves the bus into HS mode. HS mode then holds across any number of chained repeated STARTs, and only a STOP ends it. The low three bits of an accepted preamble identify the master and are published on `master_id`.

HS transfers run at up to 3.4 Mbit/s. The system clock must therefore be fast enough that each SCL phase lasts several clock periods after synchronisation.

Top module: `i2c_hs_tracker`

## Requirements
- R1: After a synchronous reset, `hs_mode`, `mcode_valid`, `hs_enter` and `hs_exit` are 0 and `master_id` is 0.
- R2: When the first byte after a START in F/S mode is `00001XXX` (MSB first, sampled on SCL rising edges) and SDA is high on the ninth SCL pulse, `mcode_valid` pulses once. From that pulse on, `master_id` equals the byte's low three bits, and it changes at no other time.
- R3: A first byte whose top five bits are not `00001` produces no event pulse and leaves `hs_mode` at 0.
- R4: A preamble byte `00001XXX` whose ninth bit is low (acknowledged) produces no `mcode_valid`. A later repeated START then leaves `hs_mode` at 0.
- R5: After an accepted preamble, the next repeated START raises `hs_mode` and gives exactly one `hs_enter` pulse, in the same cycle that `hs_mode` rises.
- R6: While `hs_mode` is 1, further repeated STARTs leave it at 1 and produce no `hs_enter` pulse.
- R7: A STOP while `hs_mode` is 1 drops `hs_mode` and gives one `hs_exit` pulse. `hs_exit` never pulses unless the block was in HS mode in the previous cycle.
- R8: A STOP at any point (in the middle of the preamble, or after an accepted preamble but before the repeated START) returns the block to F/S idle with no `hs_exit`. A following START only begins a fresh first byte.
- R9: The preamble is recognised only as the first byte after a START in F/S mode. The pattern as a later byte in F/S mode, or as the first byte after a repeated START in HS mode, produces no `mcode_valid`.
- R10: A synchronous reset while in HS mode clears `hs_mode` without an `hs_exit` pulse.
- R11: `mcode_valid`, `hs_enter` and `hs_exit` are each high for exactly one system clock cycle per event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Raw bus clock line, asynchronous to clk |
| sda_in | input | 1 | Raw bus data line, asynchronous to clk |
| hs_mode | output | 1 | High while the bus is in High-speed mode |
| mcode_valid | output | 1 | One-cycle pulse when a valid HS preamble with not-acknowledge has been seen |
| master_id | output | 3 | Low bits of the last accepted preamble |
| hs_enter | output | 1 | One-cycle pulse on entry into HS mode |
| hs_exit | output | 1 | One-cycle pulse on return to F/S mode by STOP |

## Verification
The properties assume that SDA and SCL never change in the same synchronised sample, and that each bus phase lasts more than one system clock. Under those conditions START, STOP and SCL rising edges can be told apart cleanly. The stimulus holds every bus phase for four clocks. It moves SDA only while SCL is low, except for the deliberate SDA edges with SCL high that form STARTs and STOPs. The scoreboard compares the exact order of event pulses and the preamble identifiers, so any extra or lengthened pulse shows up as a mismatch.

// File: rtl/i2c_hs_pkg.sv
package i2c_hs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,   // F/S, no transfer in progress
      ST_FIRST,  // F/S, collecting first byte after START
      ST_OTHER,  // F/S, ordinary transfer, bytes ignored
      ST_ARMED,  // preamble accepted, waiting for repeated START
      ST_HS      // High-speed mode
   } hs_state_t;

endpackage

// File: rtl/i2c_hs_sync.sv
module i2c_hs_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] pipe;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_hs_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) pipe <= '1;          // idle bus is high
      else     pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/i2c_hs_cond.sv
module i2c_hs_cond (
   input  logic clk,
   input  logic rst,
   input  logic scl,
   input  logic sda,
   output logic start_c,
   output logic stop_c,
   output logic scl_rise
);

   logic scl_q, sda_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   // SDA edge while SCL stays high marks bus conditions
   assign start_c  = scl & scl_q &  sda_q & ~sda;
   assign stop_c   = scl & scl_q & ~sda_q &  sda;
   assign scl_rise = scl & ~scl_q;

endmodule

// File: rtl/i2c_hs_byte.sv
module i2c_hs_byte #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_c,
   input  logic              stop_c,
   input  logic              scl_rise,
   input  logic              sda,
   output logic              byte_done,
   output logic [DATA_W-1:0] byte_val,
   output logic              ninth_bit
);

   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] shreg;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("i2c_hs_byte: DATA_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt   <= '0;
         shreg <= '0;
      end else if (start_c || stop_c) begin
         cnt <= '0;
      end else if (scl_rise) begin
         if (cnt == LAST) begin
            cnt <= '0;
         end else begin
            shreg <= {shreg[DATA_W-2:0], sda};
            cnt   <= cnt + 1'b1;
         end
      end
   end

   assign byte_done = scl_rise && !start_c && !stop_c && (cnt == LAST);
   assign byte_val  = shreg;
   assign ninth_bit = sda;

endmodule

// File: rtl/i2c_hs_fsm.sv
module i2c_hs_fsm
   import i2c_hs_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ID_W   = 3,
   parameter logic [DATA_W-ID_W-1:0] CODE_PREFIX = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_c,
   input  logic              stop_c,
   input  logic              byte_done,
   input  logic [DATA_W-1:0] byte_val,
   input  logic              ninth_bit,
   output logic              hs_mode,
   output logic              mcode_valid,
   output logic [ID_W-1:0]   master_id,
   output logic              hs_enter,
   output logic              hs_exit
);

   localparam int PFX_W = DATA_W - ID_W;

   hs_state_t state;
   logic      code_hit;

   assign code_hit = (byte_val[DATA_W-1 -: PFX_W] == CODE_PREFIX) && ninth_bit;

   always_ff @(posedge clk) begin
      if (rst) begin
         state       <= ST_IDLE;
         mcode_valid <= 1'b0;
         hs_enter    <= 1'b0;
         hs_exit     <= 1'b0;
         master_id   <= '0;
      end else begin
         mcode_valid <= 1'b0;
         hs_enter    <= 1'b0;
         hs_exit     <= 1'b0;
         if (stop_c) begin
            if (state == ST_HS) hs_exit <= 1'b1;
            state <= ST_IDLE;
         end else if (start_c) begin
            case (state)
               ST_HS:    state <= ST_HS;
               ST_ARMED: begin
                  state    <= ST_HS;
                  hs_enter <= 1'b1;
               end
               default:  state <= ST_FIRST;
            endcase
         end else if (byte_done && state == ST_FIRST) begin
            if (code_hit) begin
               state       <= ST_ARMED;
               mcode_valid <= 1'b1;
               master_id   <= byte_val[ID_W-1:0];
            end else begin
               state <= ST_OTHER;
            end
         end
      end
   end

   assign hs_mode = (state == ST_HS);

endmodule

// File: rtl/i2c_hs_tracker.sv
module i2c_hs_tracker #(
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 8,
   parameter int ID_W        = 3,
   parameter logic [DATA_W-ID_W-1:0] CODE_PREFIX = 5'b00001
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            scl_in,
   input  logic            sda_in,
   output logic            hs_mode,
   output logic            mcode_valid,
   output logic [ID_W-1:0] master_id,
   output logic            hs_enter,
   output logic            hs_exit
);

   logic [1:0]        bus_s;
   logic              scl_s, sda_s;
   logic              start_c, stop_c, scl_rise;
   logic              byte_done, ninth_bit;
   logic [DATA_W-1:0] byte_val;

   generate
      if (ID_W < 1 || ID_W >= DATA_W) begin : g_bad_id
         $error("i2c_hs_tracker: ID_W must be in 1..DATA_W-1");
      end
   endgenerate

   i2c_hs_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({scl_in, sda_in}),
      .q   (bus_s)
   );

   assign scl_s = bus_s[1];
   assign sda_s = bus_s[0];

   i2c_hs_cond u_cond (
      .clk      (clk),
      .rst      (rst),
      .scl      (scl_s),
      .sda      (sda_s),
      .start_c  (start_c),
      .stop_c   (stop_c),
      .scl_rise (scl_rise)
   );

   i2c_hs_byte #(.DATA_W(DATA_W)) u_byte (
      .clk       (clk),
      .rst       (rst),
      .start_c   (start_c),
      .stop_c    (stop_c),
      .scl_rise  (scl_rise),
      .sda       (sda_s),
      .byte_done (byte_done),
      .byte_val  (byte_val),
      .ninth_bit (ninth_bit)
   );

   i2c_hs_fsm #(.DATA_W(DATA_W), .ID_W(ID_W), .CODE_PREFIX(CODE_PREFIX)) u_fsm (
      .clk         (clk),
      .rst         (rst),
      .start_c     (start_c),
      .stop_c      (stop_c),
      .byte_done   (byte_done),
      .byte_val    (byte_val),
      .ninth_bit   (ninth_bit),
      .hs_mode     (hs_mode),
      .mcode_valid (mcode_valid),
      .master_id   (master_id),
      .hs_enter    (hs_enter),
      .hs_exit     (hs_exit)
   );

endmodule

// File: rtl/i2c_hs_tracker_chk.sv
module i2c_hs_tracker_chk #(
   parameter int ID_W = 3
) (
   input logic            clk,
   input logic            rst,
   input logic            hs_mode,
   input logic            mcode_valid,
   input logic [ID_W-1:0] master_id,
   input logic            hs_enter,
   input logic            hs_exit
);

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!hs_mode && !hs_enter && !hs_exit && !mcode_valid));

   // R2
   id_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!mcode_valid && !$past(rst)) |-> $stable(master_id));

   // R5
   enter_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(hs_mode) |-> hs_enter);

   // R6
   enter_once_chk: assert property (@(posedge clk) disable iff (rst)
      hs_enter |-> (hs_mode && !$past(hs_mode)));

   // R7
   exit_fall_chk: assert property (@(posedge clk) disable iff (rst)
      ($fell(hs_mode) && !$past(rst)) |-> hs_exit);

   // R7
   exit_from_hs_chk: assert property (@(posedge clk) disable iff (rst)
      hs_exit |-> (!hs_mode && $past(hs_mode)));

   // R9
   mcode_fs_chk: assert property (@(posedge clk) disable iff (rst)
      mcode_valid |-> !hs_mode);

   // R11
   mcode_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      mcode_valid |=> !mcode_valid);

   // R11
   enter_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      hs_enter |=> !hs_enter);

   // R11
   exit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      hs_exit |=> !hs_exit);

endmodule

bind i2c_hs_tracker i2c_hs_tracker_chk #(.ID_W(ID_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .hs_mode     (hs_mode),
   .mcode_valid (mcode_valid),
   .master_id   (master_id),
   .hs_enter    (hs_enter),
   .hs_exit     (hs_exit)
);

// File: tb/i2c_hs_tracker_test.sv
module i2c_hs_tracker_test;

   localparam int EV_MC = 0;
   localparam int EV_EN = 1;
   localparam int EV_EX = 2;

   typedef struct {
      int    kind;
      int    id;
      string req;
   } item_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       scl = 1'b1;
   logic       sda = 1'b1;
   logic       hs_mode, mcode_valid, hs_enter, hs_exit;
   logic [2:0] master_id;

   int    total = 0;
   int    bad   = 0;
   bit    done  = 1'b0;
   item_t expq[$];

   always #10 clk = ~clk;

   i2c_hs_tracker uut (
      .clk         (clk),
      .rst         (rst),
      .scl_in      (scl),
      .sda_in      (sda),
      .hs_mode     (hs_mode),
      .mcode_valid (mcode_valid),
      .master_id   (master_id),
      .hs_enter    (hs_enter),
      .hs_exit     (hs_exit)
   );

   task automatic expect_ev(int kind, int id, string req);
      item_t it;
      it.kind = kind;
      it.id   = id;
      it.req  = req;
      expq.push_back(it);
   endtask

   task automatic got(int kind, int id);
      item_t it;
      total++;
      if (expq.size() == 0) begin
         bad++;
         $display("FAIL R11 unexpected event: actual kind=%0d id=%0d expected none", kind, id);
      end else begin
         it = expq.pop_front();
         if (it.kind != kind || it.id != id) begin
            bad++;
            $display("FAIL %s event: actual kind=%0d id=%0d expected kind=%0d id=%0d",
                     it.req, kind, id, it.kind, it.id);
         end
      end
   endtask

   // monitor
   always @(negedge clk) begin
      if (!rst && !done) begin
         if (mcode_valid) got(EV_MC, int'(master_id));
         if (hs_enter)    got(EV_EN, 0);
         if (hs_exit)     got(EV_EX, 0);
      end
   end

   task automatic chk(string req, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s level: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic qw;
      repeat (4) @(negedge clk);
   endtask

   task automatic settle;
      repeat (10) @(negedge clk);
   endtask

   task automatic bus_start;
      sda = 1'b1; qw;
      scl = 1'b1; qw;
      sda = 1'b0; qw;
      scl = 1'b0; qw;
   endtask

   task automatic bus_stop;
      sda = 1'b0; qw;
      scl = 1'b1; qw;
      sda = 1'b1; qw; qw;
   endtask

   task automatic send_bit(logic b);
      sda = b; qw;
      scl = 1'b1; qw; qw;
      scl = 1'b0; qw;
   endtask

   task automatic send_byte(logic [7:0] b, logic ninth);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      send_bit(ninth);
   endtask

   task automatic fin;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired");
         fin();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", hs_mode, 1'b0);
      chk("R1", mcode_valid | hs_enter | hs_exit, 1'b0);
      chk("R1", master_id == 3'd0, 1'b1);
      rst = 1'b0;
      settle;

      // R3: ordinary transfer
      bus_start;
      send_byte(8'hA4, 1'b0);
      send_byte(8'h55, 1'b0);
      settle;
      chk("R3", hs_mode, 1'b0);
      bus_stop;
      settle;

      // R2 / R5 / R6 / R9 / R7
      expect_ev(EV_MC, 5, "R2");
      bus_start;
      send_byte(8'h0D, 1'b1);
      settle;
      chk("R2", master_id == 3'd5, 1'b1);
      chk("R2", hs_mode, 1'b0);
      expect_ev(EV_EN, 0, "R5");
      bus_start;
      settle;
      chk("R5", hs_mode, 1'b1);
      send_byte(8'hA0, 1'b0);
      send_byte(8'h3C, 1'b0);
      bus_start;
      send_byte(8'h09, 1'b1);     // R9: pattern inside HS
      bus_start;
      send_byte(8'hA1, 1'b0);
      settle;
      chk("R6", hs_mode, 1'b1);
      chk("R9", master_id == 3'd5, 1'b1);
      expect_ev(EV_EX, 0, "R7");
      bus_stop;
      settle;
      chk("R7", hs_mode, 1'b0);

      // R4: acknowledged preamble
      bus_start;
      send_byte(8'h0B, 1'b0);
      bus_start;
      settle;
      chk("R4", hs_mode, 1'b0);
      chk("R4", master_id == 3'd5, 1'b1);
      bus_stop;
      settle;

      // R8: STOP in the middle of the preamble
      bus_start;
      for (int i = 0; i < 5; i++) send_bit(1'b0);
      bus_stop;
      bus_start;
      send_byte(8'hA0, 1'b0);
      settle;
      chk("R8", hs_mode, 1'b0);
      bus_stop;
      settle;

      // R8: STOP after accepted preamble, before repeated START
      expect_ev(EV_MC, 7, "R8");
      bus_start;
      send_byte(8'h0F, 1'b1);
      bus_stop;
      bus_start;
      settle;
      chk("R8", hs_mode, 1'b0);
      send_byte(8'hA2, 1'b0);
      bus_stop;
      settle;

      // R9: pattern as second byte in F/S
      bus_start;
      send_byte(8'h50, 1'b0);
      send_byte(8'h0A, 1'b1);
      bus_start;
      settle;
      chk("R9", hs_mode, 1'b0);
      chk("R9", master_id == 3'd7, 1'b1);
      bus_stop;
      settle;

      // R10: reset while in HS
      expect_ev(EV_MC, 2, "R10");
      bus_start;
      send_byte(8'h0A, 1'b1);
      expect_ev(EV_EN, 0, "R10");
      bus_start;
      settle;
      chk("R10", hs_mode, 1'b1);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10", hs_mode, 1'b0);
      rst = 1'b0;
      bus_stop;
      settle;
      chk("R10", hs_mode, 1'b0);

      // R11: every expected pulse consumed exactly once
      total++;
      if (expq.size() != 0) begin
         bad++;
         $display("FAIL R11 missing events: actual left=%0d expected 0", expq.size());
      end
      fin();
   end

endmodule